// File: doc/BRIEF.md
# Queue-Port Messaging Unit

This unit connects a host register bus to an embedded I/O processor and carries opaque 32-bit request tokens in both directions. The host reads one queue-port address to take a free device packet and writes the same address to post a request. It reads a second queue-port address to collect a completion and writes that address to hand a device packet back to the free pool. The processor side sees the other end of each of the four FIFOs (free, post, completion, return) as simple push/pop strobes. A token for a request held in host memory is bit 31 set, OR'd with the 32-byte-aligned bus address shifted right by five. The unit does not interpret tokens and passes them unchanged.

Two message registers run in each direction. A host command written to inbound message 0 is complete once the processor writes the same value to outbound message 0. A doorbell register collects host-set bits for the processor. Each direction has a status register and a mask register, and each drives an interrupt line that is the OR of the unmasked status bits.

The host read path is a two-state machine. ST_IDLE means no read response is pending. ST_RESP presents registered read data with hs_rvalid high. A read request moves the machine to ST_RESP, or keeps it there. Any cycle without a read request returns it to ST_IDLE.

Top module: `qport_msg_unit`

## Requirements
- R1: After reset, hs_rvalid, hs_irq and dv_irq are low, both status registers read 0, both mask registers read 0x1F (all masked), and no FIFO holds a token.
- R2: A host read request (hs_req=1, hs_wr=0) is answered on the following cycle with hs_rvalid=1 and the register's value on hs_rdata. The offsets are: inbound message 0 at 0x10, inbound message 1 at 0x14, outbound message 0 at 0x18, outbound message 1 at 0x1C, doorbell at 0x20, inbound status at 0x24, inbound mask at 0x28, outbound status at 0x30, outbound mask at 0x34, inbound queue port at 0x40 and outbound queue port at 0x44.
- R3: A read of 0x40 pops the oldest token that the processor pushed into the free FIFO. When that FIFO is empty, the read returns 0xFFFFFFFF and changes no FIFO.
- R4: A write to 0x40 pushes the data into the post FIFO. The processor receives the tokens in order and bit-exact, host-memory tokens included.
- R5: A processor completion push is returned in order by reads of 0x44. Outbound status bit 3 is 1 exactly while completions remain, and writing 1 to that bit does not clear it.
- R6: A write to 0x44 pushes the data into the return FIFO, which the processor pops in order.
- R7: A host write to 0x10 or 0x14 updates dv_imsg0 or dv_imsg1 and sets inbound status bit 0 or bit 1. A processor write with dv_omsg_idx 0 or 1 updates outbound message 0 or 1 and sets outbound status bit 0 or bit 1.
- R8: A host write to 0x20 ORs the data into dv_doorbell and sets inbound status bit 2. dv_db_clr clears the doorbell bits where it is 1.
- R9: Status bits 0, 1, 2 and 4 are sticky. They are cleared by writing 1 (host writes to 0x24 or 0x30, or dv_istat_clr for inbound status). A set in the same cycle as a clear wins.
- R10: hs_irq is the OR of (outbound status AND NOT outbound mask). dv_irq is the same function of the inbound pair. Inbound status bit 3 is 1 while the post FIFO is not empty.
- R11: A push into a full FIFO is dropped and leaves its contents intact. A dropped completion sets outbound status bit 4. A dropped post, return or free push sets inbound status bit 4. Each FIFO depth is a parameter (default 4).
- R12: A read of an empty 0x44 in the same cycle as a completion push returns 0xFFFFFFFF, and the pushed token is returned by the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hs_req | input | 1 | Host access request |
| hs_wr | input | 1 | Host access is a write |
| hs_addr | input | 8 | Host register offset |
| hs_wdata | input | 32 | Host write data |
| hs_rvalid | output | 1 | Read response valid |
| hs_rdata | output | 32 | Read response data |
| hs_irq | output | 1 | Interrupt to host |
| dv_free_push | input | 1 | Processor pushes a free packet token |
| dv_free_token | input | 32 | Free packet token |
| dv_post_pop | input | 1 | Processor pops a posted request |
| dv_post_valid | output | 1 | Post FIFO not empty |
| dv_post_token | output | 32 | Oldest posted token |
| dv_cmpl_push | input | 1 | Processor pushes a completion |
| dv_cmpl_token | input | 32 | Completion token |
| dv_ret_pop | input | 1 | Processor pops a returned packet |
| dv_ret_valid | output | 1 | Return FIFO not empty |
| dv_ret_token | output | 32 | Oldest returned token |
| dv_omsg_we | input | 1 | Processor writes an outbound message |
| dv_omsg_idx | input | 1 | Outbound message select |
| dv_omsg_data | input | 32 | Outbound message value |
| dv_imsg0 | output | 32 | Inbound message 0 |
| dv_imsg1 | output | 32 | Inbound message 1 |
| dv_doorbell | output | 32 | Doorbell bits |
| dv_db_clr | input | 32 | Doorbell clear bits |
| dv_istat_clr | input | 5 | Inbound status clear bits |
| dv_irq | output | 1 | Interrupt to processor |

## Verification
Two of this block's functions can fall in the same cycle.

The first pair is a host pop of the completion queue and a processor push into it. The bench drives a read of an empty 0x44 on the same edge as a completion push. The read must return 0xFFFFFFFF, and a second read must return the token.

The second pair is a host write-one-to-clear of a message status bit and a processor outbound message write. The bench drives both on one edge and judges that the bit stays set.

// File: rtl/qmu_pkg.sv
package qmu_pkg;
    localparam int ADDR_W = 8;
    localparam int STAT_W = 5;

    localparam logic [ADDR_W-1:0] A_IMSG0 = 8'h10;
    localparam logic [ADDR_W-1:0] A_IMSG1 = 8'h14;
    localparam logic [ADDR_W-1:0] A_OMSG0 = 8'h18;
    localparam logic [ADDR_W-1:0] A_OMSG1 = 8'h1C;
    localparam logic [ADDR_W-1:0] A_DBELL = 8'h20;
    localparam logic [ADDR_W-1:0] A_ISTAT = 8'h24;
    localparam logic [ADDR_W-1:0] A_IMASK = 8'h28;
    localparam logic [ADDR_W-1:0] A_OSTAT = 8'h30;
    localparam logic [ADDR_W-1:0] A_OMASK = 8'h34;
    localparam logic [ADDR_W-1:0] A_INQ   = 8'h40;
    localparam logic [ADDR_W-1:0] A_OUTQ  = 8'h44;

    // status bit positions
    localparam int SB_MSG0 = 0;
    localparam int SB_MSG1 = 1;
    localparam int SB_DB   = 2;
    localparam int SB_QNE  = 3;
    localparam int SB_OVF  = 4;

    localparam logic [31:0] EMPTY_TOKEN = 32'hFFFF_FFFF;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rd_state_t;
endpackage

// File: rtl/qmu_fifo.sv
module qmu_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full,
    output logic         dropped
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dropped = push && full;
    assign dout    = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            if (do_push && !do_pop)      cnt <= cnt + 1'b1;
            else if (do_pop && !do_push) cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    p_cnt_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
    p_drop_keeps_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> full);
    p_empty_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> empty);
endmodule

// File: rtl/qmu_intc.sv
module qmu_intc #(
    parameter int          W         = 5,
    parameter logic [W-1:0] LIVE_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] level,
    input  logic [W-1:0] clr,
    input  logic         mask_we,
    input  logic [W-1:0] mask_wd,
    output logic [W-1:0] status,
    output logic [W-1:0] mask,
    output logic         irq
);
    logic [W-1:0] sticky_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)       sticky_q[i] <= 1'b0;
            else if (set[i])  sticky_q[i] <= 1'b1;
            else if (clr[i])  sticky_q[i] <= 1'b0;
        end
        if (!LIVE_MASK[i]) begin : g_sticky_chk
            p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
                set[i] |=> status[i]);
            p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (clr[i] && !set[i]) |=> !status[i]);
        end
    end

    assign status = (sticky_q & ~LIVE_MASK) | (level & LIVE_MASK);

    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '1;
        else if (mask_we) mask <= mask_wd;
    end

    assign irq = |(status & ~mask);
endmodule

// File: rtl/qport_msg_unit.sv
module qport_msg_unit
    import qmu_pkg::*;
#(
    parameter int FREE_DEPTH = 4,
    parameter int POST_DEPTH = 4,
    parameter int CMPL_DEPTH = 4,
    parameter int RET_DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hs_req,
    input  logic              hs_wr,
    input  logic [ADDR_W-1:0] hs_addr,
    input  logic [31:0]       hs_wdata,
    output logic              hs_rvalid,
    output logic [31:0]       hs_rdata,
    output logic              hs_irq,
    input  logic              dv_free_push,
    input  logic [31:0]       dv_free_token,
    input  logic              dv_post_pop,
    output logic              dv_post_valid,
    output logic [31:0]       dv_post_token,
    input  logic              dv_cmpl_push,
    input  logic [31:0]       dv_cmpl_token,
    input  logic              dv_ret_pop,
    output logic              dv_ret_valid,
    output logic [31:0]       dv_ret_token,
    input  logic              dv_omsg_we,
    input  logic              dv_omsg_idx,
    input  logic [31:0]       dv_omsg_data,
    output logic [31:0]       dv_imsg0,
    output logic [31:0]       dv_imsg1,
    output logic [31:0]       dv_doorbell,
    input  logic [31:0]       dv_db_clr,
    input  logic [STAT_W-1:0] dv_istat_clr,
    output logic              dv_irq
);
    localparam logic [STAT_W-1:0] LIVE = STAT_W'(1) << SB_QNE;

    logic rd_req, wr_req;
    assign rd_req = hs_req && !hs_wr;
    assign wr_req = hs_req && hs_wr;

    // FIFO plumbing
    logic [31:0] free_dout, cmpl_dout;
    logic free_empty, free_full, free_drop;
    logic post_empty, post_full, post_drop;
    logic cmpl_empty, cmpl_full, cmpl_drop;
    logic ret_empty, ret_full, ret_drop;

    qmu_fifo #(.DEPTH(FREE_DEPTH), .W(32)) i_free (
        .clk, .rst_n, .push(dv_free_push), .din(dv_free_token),
        .pop(rd_req && hs_addr == A_INQ), .dout(free_dout),
        .empty(free_empty), .full(free_full), .dropped(free_drop));

    qmu_fifo #(.DEPTH(POST_DEPTH), .W(32)) i_post (
        .clk, .rst_n, .push(wr_req && hs_addr == A_INQ), .din(hs_wdata),
        .pop(dv_post_pop), .dout(dv_post_token),
        .empty(post_empty), .full(post_full), .dropped(post_drop));

    qmu_fifo #(.DEPTH(CMPL_DEPTH), .W(32)) i_cmpl (
        .clk, .rst_n, .push(dv_cmpl_push), .din(dv_cmpl_token),
        .pop(rd_req && hs_addr == A_OUTQ), .dout(cmpl_dout),
        .empty(cmpl_empty), .full(cmpl_full), .dropped(cmpl_drop));

    qmu_fifo #(.DEPTH(RET_DEPTH), .W(32)) i_ret (
        .clk, .rst_n, .push(wr_req && hs_addr == A_OUTQ), .din(hs_wdata),
        .pop(dv_ret_pop), .dout(dv_ret_token),
        .empty(ret_empty), .full(ret_full), .dropped(ret_drop));

    assign dv_post_valid = !post_empty;
    assign dv_ret_valid  = !ret_empty;

    // message and doorbell registers
    logic [31:0] omsg0_q, omsg1_q;
    logic imsg0_w, imsg1_w, omsg0_w, omsg1_w, db_w;

    assign imsg0_w = wr_req && hs_addr == A_IMSG0;
    assign imsg1_w = wr_req && hs_addr == A_IMSG1;
    assign db_w    = wr_req && hs_addr == A_DBELL;
    assign omsg0_w = dv_omsg_we && !dv_omsg_idx;
    assign omsg1_w = dv_omsg_we && dv_omsg_idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dv_imsg0    <= '0;
            dv_imsg1    <= '0;
            omsg0_q     <= '0;
            omsg1_q     <= '0;
            dv_doorbell <= '0;
        end else begin
            if (imsg0_w) dv_imsg0 <= hs_wdata;
            if (imsg1_w) dv_imsg1 <= hs_wdata;
            if (omsg0_w) omsg0_q  <= dv_omsg_data;
            if (omsg1_w) omsg1_q  <= dv_omsg_data;
            dv_doorbell <= (dv_doorbell & ~dv_db_clr) | (db_w ? hs_wdata : 32'h0);
        end
    end

    // interrupt status and mask, one per direction
    logic [STAT_W-1:0] istat, imask, ostat, omask;
    logic [STAT_W-1:0] iset, oset, ilevel, olevel, iclr, oclr;

    assign iset   = {post_drop || ret_drop || free_drop, 1'b0, db_w, imsg1_w, imsg0_w};
    assign oset   = {cmpl_drop, 1'b0, 1'b0, omsg1_w, omsg0_w};
    assign ilevel = {1'b0, !post_empty, 3'b000};
    assign olevel = {1'b0, !cmpl_empty, 3'b000};
    assign iclr   = dv_istat_clr |
                    ((wr_req && hs_addr == A_ISTAT) ? hs_wdata[STAT_W-1:0] : '0);
    assign oclr   = (wr_req && hs_addr == A_OSTAT) ? hs_wdata[STAT_W-1:0] : '0;

    qmu_intc #(.W(STAT_W), .LIVE_MASK(LIVE)) i_in_intc (
        .clk, .rst_n, .set(iset), .level(ilevel), .clr(iclr),
        .mask_we(wr_req && hs_addr == A_IMASK), .mask_wd(hs_wdata[STAT_W-1:0]),
        .status(istat), .mask(imask), .irq(dv_irq));

    qmu_intc #(.W(STAT_W), .LIVE_MASK(LIVE)) i_out_intc (
        .clk, .rst_n, .set(oset), .level(olevel), .clr(oclr),
        .mask_we(wr_req && hs_addr == A_OMASK), .mask_wd(hs_wdata[STAT_W-1:0]),
        .status(ostat), .mask(omask), .irq(hs_irq));

    // host read path: state machine plus registered data
    rd_state_t state_q, state_d;
    logic [31:0] rd_mux;

    always_comb begin
        unique case (hs_addr)
            A_IMSG0: rd_mux = dv_imsg0;
            A_IMSG1: rd_mux = dv_imsg1;
            A_OMSG0: rd_mux = omsg0_q;
            A_OMSG1: rd_mux = omsg1_q;
            A_DBELL: rd_mux = dv_doorbell;
            A_ISTAT: rd_mux = 32'(istat);
            A_IMASK: rd_mux = 32'(imask);
            A_OSTAT: rd_mux = 32'(ostat);
            A_OMASK: rd_mux = 32'(omask);
            A_INQ:   rd_mux = free_empty ? EMPTY_TOKEN : free_dout;
            A_OUTQ:  rd_mux = cmpl_empty ? EMPTY_TOKEN : cmpl_dout;
            default: rd_mux = 32'h0;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = rd_req ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = rd_req ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      hs_rdata <= '0;
        else if (rd_req) hs_rdata <= rd_mux;
    end

    assign hs_rvalid = (state_q == ST_RESP);

    p_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> hs_rvalid);
    p_noresp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !hs_rvalid);
    p_empty_inq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && hs_addr == A_INQ && free_empty) |=> hs_rdata == EMPTY_TOKEN);
    p_empty_outq_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && hs_addr == A_OUTQ && cmpl_empty) |=> hs_rdata == EMPTY_TOKEN);
    p_cmpl_ovf_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_drop |=> ostat[SB_OVF]);
    p_qne_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dv_cmpl_push && !cmpl_full) |=> ostat[SB_QNE]);
endmodule

// File: tb/test_qport_msg_unit.sv
module test_qport_msg_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hs_req = 0, hs_wr = 0;
    logic [7:0]  hs_addr = '0;
    logic [31:0] hs_wdata = '0;
    logic        hs_rvalid, hs_irq, dv_post_valid, dv_ret_valid, dv_irq;
    logic [31:0] hs_rdata, dv_post_token, dv_ret_token, dv_imsg0, dv_imsg1, dv_doorbell;
    logic        dv_free_push = 0, dv_post_pop = 0, dv_cmpl_push = 0, dv_ret_pop = 0;
    logic        dv_omsg_we = 0, dv_omsg_idx = 0;
    logic [31:0] dv_free_token = '0, dv_cmpl_token = '0, dv_omsg_data = '0, dv_db_clr = '0;
    logic [4:0]  dv_istat_clr = '0;

    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    qport_msg_unit i_qport_msg_unit (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); hs_req = 1; hs_wr = 1; hs_addr = a; hs_wdata = d;
        @(negedge clk); hs_req = 0; hs_wr = 0;
    endtask

    task automatic hread(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); hs_req = 1; hs_wr = 0; hs_addr = a;
        @(negedge clk); hs_req = 0;
        chk({tag, " rvalid"}, 32'(hs_rvalid), 32'd1);
        chk(tag, hs_rdata, exp);
    endtask

    task automatic dfree(input logic [31:0] t);
        @(negedge clk); dv_free_push = 1; dv_free_token = t;
        @(negedge clk); dv_free_push = 0;
    endtask

    task automatic dcmpl(input logic [31:0] t);
        @(negedge clk); dv_cmpl_push = 1; dv_cmpl_token = t;
        @(negedge clk); dv_cmpl_push = 0;
    endtask

    task automatic dtake_post(input logic [31:0] exp, input string tag);
        @(negedge clk);
        chk({tag, " valid"}, 32'(dv_post_valid), 32'd1);
        chk(tag, dv_post_token, exp);
        dv_post_pop = 1;
        @(negedge clk); dv_post_pop = 0;
    endtask

    task automatic t_reset;
        chk("R1 rvalid", 32'(hs_rvalid), 0);
        chk("R1 hs_irq", 32'(hs_irq), 0);
        chk("R1 dv_irq", 32'(dv_irq), 0);
        hread(8'h34, 32'h1F, "R1 omask");
        hread(8'h28, 32'h1F, "R1 imask");
        hread(8'h30, 32'h0, "R1 ostat");
        hread(8'h24, 32'h0, "R1 istat");
        @(negedge clk);
        chk("R2 rvalid drops", 32'(hs_rvalid), 0);
    endtask

    task automatic t_free;
        hread(8'h40, 32'hFFFF_FFFF, "R3 empty inq");
        dfree(32'h100); dfree(32'h200); dfree(32'h300);
        hread(8'h40, 32'h100, "R3 free 1");
        hread(8'h40, 32'h200, "R3 free 2");
        hread(8'h40, 32'h300, "R3 free 3");
        hread(8'h40, 32'hFFFF_FFFF, "R3 empty again");
        dfree(32'h400);
        hread(8'h40, 32'h400, "R3 after empty read");
    endtask

    task automatic t_post;
        hwrite(8'h40, 32'h8000_0000 | (32'h0000_1080 >> 5));
        hwrite(8'h40, 32'h0000_1234);
        hread(8'h24, 32'h08, "R10 istat qne");
        dtake_post(32'h8000_0084, "R4 host token");
        dtake_post(32'h0000_1234, "R4 device offset");
        chk("R4 post drained", 32'(dv_post_valid), 0);
    endtask

    task automatic t_cmpl;
        dcmpl(32'hAAAA_0001); dcmpl(32'h5);
        hread(8'h30, 32'h08, "R5 ostat qne");
        chk("R10 masked irq", 32'(hs_irq), 0);
        hwrite(8'h34, 32'h0);
        chk("R10 unmasked irq", 32'(hs_irq), 1);
        hwrite(8'h30, 32'h08);
        hread(8'h30, 32'h08, "R5 qne not clearable");
        hread(8'h44, 32'hAAAA_0001, "R5 cmpl 1");
        hread(8'h44, 32'h5, "R5 cmpl 2");
        hread(8'h30, 32'h0, "R5 ostat empty");
        chk("R10 irq low", 32'(hs_irq), 0);
    endtask

    task automatic t_ret;
        hwrite(8'h44, 32'h700);
        hwrite(8'h44, 32'h800);
        @(negedge clk);
        chk("R6 ret valid", 32'(dv_ret_valid), 1);
        chk("R6 ret 1", dv_ret_token, 32'h700);
        dv_ret_pop = 1;
        @(negedge clk); dv_ret_pop = 0;
        chk("R6 ret 2", dv_ret_token, 32'h800);
        dv_ret_pop = 1;
        @(negedge clk); dv_ret_pop = 0;
        chk("R6 ret drained", 32'(dv_ret_valid), 0);
    endtask

    task automatic t_msg;
        hwrite(8'h10, 32'hC0DE);
        chk("R7 imsg0", dv_imsg0, 32'hC0DE);
        hwrite(8'h14, 32'hBEEF);
        chk("R7 imsg1", dv_imsg1, 32'hBEEF);
        hread(8'h24, 32'h03, "R7 istat");
        chk("R10 dv_irq masked", 32'(dv_irq), 0);
        hwrite(8'h28, 32'h1C);
        chk("R10 dv_irq", 32'(dv_irq), 1);
        @(negedge clk); dv_istat_clr = 5'h03;
        @(negedge clk); dv_istat_clr = 0;
        chk("R9 dev clear", 32'(dv_irq), 0);
        @(negedge clk); dv_omsg_we = 1; dv_omsg_idx = 0; dv_omsg_data = 32'hC0DE;
        @(negedge clk); dv_omsg_we = 0;
        hread(8'h18, 32'hC0DE, "R7 omsg0 echo");
        hread(8'h30, 32'h01, "R7 ostat msg0");
        chk("R10 hs_irq msg", 32'(hs_irq), 1);
        hwrite(8'h30, 32'h1F);
        hread(8'h30, 32'h0, "R9 w1c");
        // collision: message write and clear on one edge
        @(negedge clk);
        dv_omsg_we = 1; dv_omsg_idx = 1; dv_omsg_data = 32'h77;
        hs_req = 1; hs_wr = 1; hs_addr = 8'h30; hs_wdata = 32'h02;
        @(negedge clk); dv_omsg_we = 0; hs_req = 0; hs_wr = 0;
        hread(8'h30, 32'h02, "R9 set wins");
        hread(8'h1C, 32'h77, "R7 omsg1");
        hwrite(8'h30, 32'h02);
    endtask

    task automatic t_doorbell;
        hwrite(8'h20, 32'h5);
        hwrite(8'h20, 32'h30);
        chk("R8 doorbell or", dv_doorbell, 32'h35);
        hread(8'h24, 32'h04, "R8 istat db");
        @(negedge clk); dv_db_clr = 32'h4;
        @(negedge clk); dv_db_clr = 0;
        chk("R8 doorbell clr", dv_doorbell, 32'h31);
        hwrite(8'h24, 32'h04);
        hread(8'h24, 32'h0, "R9 host w1c istat");
    endtask

    task automatic t_overflow;
        for (int i = 0; i < 5; i++) dcmpl(32'h10 + i);
        hread(8'h30, 32'h18, "R11 ostat ovf");
        for (int i = 0; i < 4; i++) hread(8'h44, 32'h10 + i, "R11 kept");
        hread(8'h44, 32'hFFFF_FFFF, "R11 drop lost");
        hwrite(8'h30, 32'h10);
        hread(8'h30, 32'h0, "R11 ovf cleared");
        for (int i = 0; i < 5; i++) hwrite(8'h40, 32'h20 + i);
        hread(8'h24, 32'h18, "R11 istat ovf");
        for (int i = 0; i < 4; i++) dtake_post(32'h20 + i, "R11 post kept");
        chk("R11 post empty", 32'(dv_post_valid), 0);
    endtask

    task automatic t_collide;
        @(negedge clk);
        hs_req = 1; hs_wr = 0; hs_addr = 8'h44;
        dv_cmpl_push = 1; dv_cmpl_token = 32'hABCD;
        @(negedge clk); hs_req = 0; dv_cmpl_push = 0;
        chk("R12 empty read", hs_rdata, 32'hFFFF_FFFF);
        hread(8'h44, 32'hABCD, "R12 token kept");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset;
        t_free;
        t_post;
        t_cmpl;
        t_ret;
        t_msg;
        t_doorbell;
        t_overflow;
        t_collide;
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule